// File: doc/BRIEF.md
# Fast Page Mode DRAM Controller

This block connects a host request port to an asynchronous fast-page-mode DRAM with a 16-bit data bus. Each host request carries a word address, a write flag, two byte enables and write data. The block splits the address into a row and a column. It puts them in turn on a shared address bus, drives the row and column strobes and the write and output-enable pins, and returns read data to the host with a single-cycle valid pulse.

A row stays open after an access. When the next request goes to the same row, only a new column strobe is issued. A request to a different row, or a row that has been held open too long, makes the block raise the row strobe and wait out the row precharge time before it opens the next row. A free-running interval timer requests refreshes. Each refresh is a row-strobe-only cycle whose row comes from a wrapping counter. All timing values are parameters counted in controller clock cycles.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: After reset the row strobe, both column strobes, the write strobe and the output enable are all high (inactive), the data driver is off, no response is valid, and the request port is ready.
- R2: When the row strobe falls, the address bus holds the row field (request address bits above the low COL_W bits). When a column strobe falls, the bus holds the column field (the low COL_W bits, zero-extended).
- R3: Byte enable bit 0 drives the lower-lane column strobe (data bits 7:0) and bit 1 drives the upper-lane strobe (bits 15:8). Only the enabled lanes are written. In a read, lanes that are not enabled return zero.
- R4: Writes are always early writes. The write strobe is low for at least one cycle before the column strobe falls and stays low until it rises. Write data is driven for the whole pulse, with the output enable high.
- R5: A read holds the write strobe high and drives the output enable low during the column pulse. The data on the bus when the pulse timer expires comes back on rsp_rdata_o with rsp_valid_o high for exactly one cycle, one response per read, in request order.
- R6: A request to the row that is already open issues no new row strobe. Only the column strobes cycle.
- R7: A request to a different row raises the row strobe first. The row strobe stays high for at least T_RP cycles before it falls again.
- R8: Between two column pulses both column strobes are high for at least T_CP cycles. The write strobe never changes while a column strobe is low, so both lanes always share one write mode.
- R9: A column strobe falls only while the row strobe is low, at least T_RCD cycles after it fell. Each column pulse lasts at least T_CAS cycles.
- R10: Every T_REF cycles a refresh is due. It closes any open row and then runs a row-strobe-only cycle with no column strobe. Its row comes from a counter that starts at 0, advances by one after each refresh and wraps at 2^ROW_W.
- R11: The row strobe never stays low longer than T_RAS_MAX + T_CAS + T_CP + 3 cycles. An open row whose active time has run out is closed before any further access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Host request valid |
| req_ready_o | output | 1 | Request accepted when high together with valid |
| req_addr_i | input | ROW_W+COL_W | Word address: row in the upper bits, column in the low COL_W bits |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_be_i | input | 2 | Byte enables, bit 0 lower lane, bit 1 upper lane |
| req_wdata_i | input | DATA_W | Write data |
| rsp_valid_o | output | 1 | One-cycle read data valid |
| rsp_rdata_o | output | DATA_W | Read data |
| dram_ras_no | output | 1 | Row strobe, active low |
| dram_casl_no | output | 1 | Lower-lane column strobe, active low |
| dram_cash_no | output | 1 | Upper-lane column strobe, active low |
| dram_we_no | output | 1 | Write strobe, active low |
| dram_oe_no | output | 1 | Output enable, active low |
| dram_addr_o | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dram_dq_o | output | DATA_W | Data toward the DRAM |
| dram_dq_oe_o | output | 1 | Enables the data driver toward the DRAM |
| dram_dq_i | input | DATA_W | Data from the DRAM |

## Verification
The pin-timing properties assume that every timing parameter is at least one cycle. They also assume that the host keeps the address, flag, enables and data steady from the moment it raises valid until the request is accepted, and never sends a request with both byte enables clear. The bench holds every field from valid to acceptance, draws byte enables only from the three non-zero codes, and builds its DRAM model so that it drives only the lanes whose column strobe is low while the output enable is low. Row addresses are drawn from a small set so that page hits, misses and timed-out rows all occur, and a long idle stretch at the end lets the refresh counter wrap.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PRE,
    ST_RADDR,
    ST_RCD,
    ST_CADDR,
    ST_CAS,
    ST_CP,
    ST_REF_ADDR,
    ST_REF
  } fpm_state_e;

  function automatic int fpm_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/fpm_downcnt.sv
module fpm_downcnt #(
  parameter int W       = 8,
  parameter int RST_VAL = 0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= W'(RST_VAL);
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/fpm_refresh.sv
module fpm_refresh #(
  parameter int ROW_W = 12,
  parameter int T_REF = 780
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ack_i,
  input  logic             done_i,
  output logic             pend_o,
  output logic [ROW_W-1:0] row_o
);

  localparam int IW = $clog2(T_REF + 1);

  logic             iv_zero;
  logic             pend_q;
  logic [ROW_W-1:0] row_q;

  fpm_downcnt #(.W(IW), .RST_VAL(T_REF - 1)) i_interval (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (iv_zero),
    .load_val_i (IW'(T_REF - 1)),
    .zero_o     (iv_zero)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      row_q  <= '0;
    end else begin
      if (iv_zero)    pend_q <= 1'b1;
      else if (ack_i) pend_q <= 1'b0;
      if (done_i)     row_q  <= row_q + 1'b1;
    end
  end

  assign pend_o = pend_q;
  assign row_o  = row_q;

endmodule

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl
  import fpm_pkg::*;
#(
  parameter int ROW_W     = 12,
  parameter int COL_W     = 10,
  parameter int DATA_W    = 16,
  parameter int T_RCD     = 2,
  parameter int T_CAS     = 2,
  parameter int T_CP      = 1,
  parameter int T_RP      = 2,
  parameter int T_RFC     = 3,
  parameter int T_RAS_MAX = 1000,
  parameter int T_REF     = 780,
  localparam int AW       = ROW_W + COL_W,
  localparam int BUS_W    = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [AW-1:0]     req_addr_i,
  input  logic              req_we_i,
  input  logic [1:0]        req_be_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              dram_ras_no,
  output logic              dram_casl_no,
  output logic              dram_cash_no,
  output logic              dram_we_no,
  output logic              dram_oe_no,
  output logic [BUS_W-1:0]  dram_addr_o,
  output logic [DATA_W-1:0] dram_dq_o,
  output logic              dram_dq_oe_o,
  input  logic [DATA_W-1:0] dram_dq_i
);

  localparam int LANES   = 2;
  localparam int TMR_MAX = fpm_max(fpm_max(fpm_max(T_RCD, T_CAS), fpm_max(T_CP, T_RP)), T_RFC);
  localparam int TW      = $clog2(TMR_MAX + 1);
  localparam int RMW     = $clog2(T_RAS_MAX + 1);

  fpm_state_e state_q, state_d;

  logic              row_open_q, row_open_d;
  logic [ROW_W-1:0]  open_row_q, open_row_d;
  logic              acc_pend_q, acc_pend_d;
  logic              rq_we_q, rq_we_d;
  logic [1:0]        rq_be_q, rq_be_d;
  logic [ROW_W-1:0]  rq_row_q, rq_row_d;
  logic [COL_W-1:0]  rq_col_q, rq_col_d;
  logic [DATA_W-1:0] rq_wdata_q, rq_wdata_d;

  logic              tmr_load, tmr_zero;
  logic [TW-1:0]     tmr_val;
  logic              rmax_zero;
  logic              ref_pend, ref_ack, ref_done;
  logic [ROW_W-1:0]  ref_row;

  logic              accept, hit, ras_exp;

  logic              ras_n_q, we_n_q, oe_n_q, dq_oe_q, rsp_valid_q;
  logic [LANES-1:0]  cas_n_q;
  logic [BUS_W-1:0]  addr_q;
  logic [DATA_W-1:0] dq_q, rdata_q;

  assign ras_exp     = row_open_q && rmax_zero;
  assign req_ready_o = (state_q == ST_IDLE) && !ref_pend && !ras_exp;
  assign accept      = req_valid_i && req_ready_o;
  assign hit         = (req_addr_i[AW-1:COL_W] == open_row_q);

  always_comb begin
    state_d    = state_q;
    row_open_d = row_open_q;
    open_row_d = open_row_q;
    acc_pend_d = acc_pend_q;
    rq_we_d    = rq_we_q;
    rq_be_d    = rq_be_q;
    rq_row_d   = rq_row_q;
    rq_col_d   = rq_col_q;
    rq_wdata_d = rq_wdata_q;
    unique case (state_q)
      ST_IDLE: begin
        if (ref_pend) begin
          if (row_open_q) begin
            state_d    = ST_PRE;
            row_open_d = 1'b0;
            acc_pend_d = 1'b0;
          end else begin
            state_d = ST_REF_ADDR;
          end
        end else if (ras_exp) begin
          state_d    = ST_PRE;
          row_open_d = 1'b0;
          acc_pend_d = 1'b0;
        end else if (accept) begin
          rq_we_d    = req_we_i;
          rq_be_d    = req_be_i;
          rq_row_d   = req_addr_i[AW-1:COL_W];
          rq_col_d   = req_addr_i[COL_W-1:0];
          rq_wdata_d = req_wdata_i;
          if (row_open_q && hit) begin
            state_d = ST_CADDR;
          end else if (row_open_q) begin
            state_d    = ST_PRE;
            row_open_d = 1'b0;
            acc_pend_d = 1'b1;
          end else begin
            state_d = ST_RADDR;
          end
        end
      end
      ST_PRE: if (tmr_zero) begin
        state_d    = acc_pend_q ? ST_RADDR : ST_IDLE;
        acc_pend_d = 1'b0;
      end
      ST_RADDR: begin
        state_d    = ST_RCD;
        row_open_d = 1'b1;
        open_row_d = rq_row_q;
      end
      ST_RCD:      if (tmr_zero) state_d = ST_CADDR;
      ST_CADDR:    state_d = ST_CAS;
      ST_CAS:      if (tmr_zero) state_d = ST_CP;
      ST_CP:       if (tmr_zero) state_d = ST_IDLE;
      ST_REF_ADDR: state_d = ST_REF;
      ST_REF:      if (tmr_zero) state_d = ST_PRE;
      default:     state_d = ST_IDLE;
    endcase
  end

  // each timed state lasts exactly its parameter in cycles
  always_comb begin
    tmr_load = (state_d != state_q);
    unique case (state_d)
      ST_PRE:  tmr_val = TW'(T_RP - 1);
      ST_RCD:  tmr_val = TW'(T_RCD - 1);
      ST_CAS:  tmr_val = TW'(T_CAS - 1);
      ST_CP:   tmr_val = TW'(T_CP - 1);
      ST_REF:  tmr_val = TW'(T_RFC - 1);
      default: tmr_val = '0;
    endcase
  end

  assign ref_ack  = (state_q == ST_IDLE) && (state_d == ST_REF_ADDR);
  assign ref_done = (state_q == ST_REF) && tmr_zero;

  fpm_downcnt #(.W(TW), .RST_VAL(0)) i_state_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  fpm_downcnt #(.W(RMW), .RST_VAL(0)) i_ras_max (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (state_q == ST_RADDR),
    .load_val_i (RMW'(T_RAS_MAX - 1)),
    .zero_o     (rmax_zero)
  );

  fpm_refresh #(.ROW_W(ROW_W), .T_REF(T_REF)) i_refresh (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ack_i  (ref_ack),
    .done_i (ref_done),
    .pend_o (ref_pend),
    .row_o  (ref_row)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      row_open_q <= 1'b0;
      open_row_q <= '0;
      acc_pend_q <= 1'b0;
      rq_we_q    <= 1'b0;
      rq_be_q    <= '0;
      rq_row_q   <= '0;
      rq_col_q   <= '0;
      rq_wdata_q <= '0;
    end else begin
      state_q    <= state_d;
      row_open_q <= row_open_d;
      open_row_q <= open_row_d;
      acc_pend_q <= acc_pend_d;
      rq_we_q    <= rq_we_d;
      rq_be_q    <= rq_be_d;
      rq_row_q   <= rq_row_d;
      rq_col_q   <= rq_col_d;
      rq_wdata_q <= rq_wdata_d;
    end
  end

  // pins registered from next state: glitch-free strobes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ras_n_q <= 1'b1;
      we_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
      dq_oe_q <= 1'b0;
      addr_q  <= '0;
      dq_q    <= '0;
    end else begin
      ras_n_q <= !((state_d inside {ST_RCD, ST_CADDR, ST_CAS, ST_CP, ST_REF}) ||
                   ((state_d == ST_IDLE) && row_open_d));
      we_n_q  <= !(rq_we_d && (state_d inside {ST_CADDR, ST_CAS}));
      dq_oe_q <= rq_we_d && (state_d inside {ST_CADDR, ST_CAS});
      oe_n_q  <= !(!rq_we_d && (state_d == ST_CAS));
      if (state_d == ST_RADDR)    addr_q <= BUS_W'(rq_row_d);
      if (state_d == ST_REF_ADDR) addr_q <= BUS_W'(ref_row);
      if (state_d == ST_CADDR)    addr_q <= BUS_W'(rq_col_d);
      if (state_d == ST_CADDR)    dq_q   <= rq_wdata_d;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cas_n_q[g] <= 1'b1;
      else         cas_n_q[g] <= !((state_d == ST_CAS) && rq_be_d[g]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rdata_q     <= '0;
    end else begin
      rsp_valid_q <= (state_q == ST_CAS) && tmr_zero && !rq_we_q;
      if ((state_q == ST_CAS) && tmr_zero && !rq_we_q) rdata_q <= dram_dq_i;
    end
  end

  assign dram_ras_no  = ras_n_q;
  assign dram_casl_no = cas_n_q[0];
  assign dram_cash_no = cas_n_q[1];
  assign dram_we_no   = we_n_q;
  assign dram_oe_no   = oe_n_q;
  assign dram_addr_o  = addr_q;
  assign dram_dq_o    = dq_q;
  assign dram_dq_oe_o = dq_oe_q;
  assign rsp_valid_o  = rsp_valid_q;
  assign rsp_rdata_o  = rdata_q;

endmodule

// File: rtl/fpm_dram_ctrl_chk.sv
module fpm_dram_ctrl_chk #(
  parameter int T_RCD     = 2,
  parameter int T_CAS     = 2,
  parameter int T_CP      = 1,
  parameter int T_RP      = 2,
  parameter int T_RAS_MAX = 1000
) (
  input logic clk_i,
  input logic rst_ni,
  input logic rsp_valid_o,
  input logic dram_ras_no,
  input logic dram_casl_no,
  input logic dram_cash_no,
  input logic dram_we_no,
  input logic dram_oe_no,
  input logic dram_dq_oe_o
);

  localparam int RAS_BOUND = T_RAS_MAX + T_CAS + T_CP + 3;

  logic        cas_hi;
  logic [31:0] ras_lo_cnt, ras_hi_cnt, cas_lo_cnt, cas_hi_cnt;

  assign cas_hi = dram_casl_no && dram_cash_no;

  // consecutive-cycle counters; high counts start saturated (precharged at power-up)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ras_lo_cnt <= '0;
      cas_lo_cnt <= '0;
      ras_hi_cnt <= 32'hffff;
      cas_hi_cnt <= 32'hffff;
    end else begin
      ras_lo_cnt <= dram_ras_no ? '0 : ras_lo_cnt + 1;
      cas_lo_cnt <= cas_hi      ? '0 : cas_lo_cnt + 1;
      ras_hi_cnt <= !dram_ras_no ? '0 : ((ras_hi_cnt < 32'hffff) ? ras_hi_cnt + 1 : ras_hi_cnt);
      cas_hi_cnt <= !cas_hi      ? '0 : ((cas_hi_cnt < 32'hffff) ? cas_hi_cnt + 1 : cas_hi_cnt);
    end
  end

  assert_wr_drive_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cas_hi && !dram_we_no) |-> (dram_dq_oe_o && dram_oe_no));

  assert_rd_oe_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dram_oe_no |-> (dram_we_no && !cas_hi && !dram_dq_oe_o));

  assert_rsp_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  assert_ras_pre_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dram_ras_no) |-> (ras_hi_cnt >= T_RP));

  assert_cas_pre_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cas_hi) |-> (cas_hi_cnt >= T_CP));

  assert_we_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cas_hi && !$past(cas_hi)) |-> $stable(dram_we_no));

  assert_cas_in_ras_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cas_hi |-> !dram_ras_no);

  assert_rcd_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cas_hi) |-> (ras_lo_cnt >= T_RCD));

  assert_cas_width_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cas_hi) |-> (cas_lo_cnt >= T_CAS));

  assert_ras_max_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ras_lo_cnt <= RAS_BOUND);

endmodule

bind fpm_dram_ctrl fpm_dram_ctrl_chk #(
  .T_RCD     (T_RCD),
  .T_CAS     (T_CAS),
  .T_CP      (T_CP),
  .T_RP      (T_RP),
  .T_RAS_MAX (T_RAS_MAX)
) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .rsp_valid_o  (rsp_valid_o),
  .dram_ras_no  (dram_ras_no),
  .dram_casl_no (dram_casl_no),
  .dram_cash_no (dram_cash_no),
  .dram_we_no   (dram_we_no),
  .dram_oe_no   (dram_oe_no),
  .dram_dq_oe_o (dram_dq_oe_o)
);

// File: tb/test_fpm_dram_ctrl.sv
`timescale 1ns/1ps
module test_fpm_dram_ctrl;

  localparam int ROW_W = 8, COL_W = 10, DW = 16;
  localparam int AW = ROW_W + COL_W, BUS_W = 10;
  localparam int T_RCD = 2, T_CAS = 2, T_CP = 1, T_RP = 2, T_RFC = 3;
  localparam int T_RAS_MAX = 30, T_REF = 60;
  localparam int RAS_BOUND = T_RAS_MAX + T_CAS + T_CP + 3;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req_valid_i = 1'b0, req_ready_o, req_we_i = 1'b0;
  logic [AW-1:0] req_addr_i = '0;
  logic [1:0] req_be_i = 2'b11;
  logic [DW-1:0] req_wdata_i = '0, rsp_rdata_o, dram_dq_o, dram_dq_i = '0;
  logic rsp_valid_o, dram_ras_no, dram_casl_no, dram_cash_no, dram_we_no, dram_oe_no, dram_dq_oe_o;
  logic [BUS_W-1:0] dram_addr_o;

  always #4 clk = ~clk;

  fpm_dram_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DW), .T_RCD(T_RCD), .T_CAS(T_CAS),
    .T_CP(T_CP), .T_RP(T_RP), .T_RFC(T_RFC), .T_RAS_MAX(T_RAS_MAX), .T_REF(T_REF)) i_fpm_dram_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_addr_i(req_addr_i), .req_we_i(req_we_i), .req_be_i(req_be_i), .req_wdata_i(req_wdata_i),
    .rsp_valid_o(rsp_valid_o), .rsp_rdata_o(rsp_rdata_o), .dram_ras_no(dram_ras_no),
    .dram_casl_no(dram_casl_no), .dram_cash_no(dram_cash_no), .dram_we_no(dram_we_no),
    .dram_oe_no(dram_oe_no), .dram_addr_o(dram_addr_o), .dram_dq_o(dram_dq_o),
    .dram_dq_oe_o(dram_dq_oe_o), .dram_dq_i(dram_dq_i));

  int checks = 0, errors = 0;
  logic [15:0] dram_mem [int];
  logic [15:0] model [int];
  logic [15:0] exp_q [$];
  logic [AW-1:0] cur_addr = '0;
  logic [1:0] cur_be = 2'b11;
  int ref_cnt = 0, acc_opens = 0;
  logic [ROW_W-1:0] exp_ref = '0;
  bit saw_wrap = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mem_get(input int k);
    return dram_mem.exists(k) ? dram_mem[k] : 16'h0;
  endfunction

  function automatic logic [15:0] model_get(input int k);
    return model.exists(k) ? model[k] : 16'h0;
  endfunction

  function automatic logic [15:0] lane_mask(input logic [1:0] be);
    return {{8{be[1]}}, {8{be[0]}}};
  endfunction

  // DRAM pin model, sampled away from the active edge
  logic prev_ras = 1'b1, prev_any = 1'b0, prev_we = 1'b1, cas_seen = 1'b0;
  int ras_lo = 0, ras_hi = 1000, cas_lo = 0, cas_hi = 1000;
  logic [ROW_W-1:0] lat_row = '0;
  logic [COL_W-1:0] lat_col = '0;

  always @(negedge clk) begin
    if (rst_ni) begin
      automatic logic any = !dram_casl_no || !dram_cash_no;
      automatic int key;
      if (prev_ras && !dram_ras_no) begin
        chk(ras_hi >= T_RP, "R7 ras precharge", ras_hi, T_RP);
        lat_row  = dram_addr_o[ROW_W-1:0];
        cas_seen = 1'b0;
      end
      if (any && !prev_any) begin
        lat_col = dram_addr_o[COL_W-1:0];
        chk(!dram_ras_no, "R9 cas under ras", dram_ras_no, 0);
        chk(ras_lo >= T_RCD, "R9 ras-to-cas", ras_lo, T_RCD);
        chk(cas_hi >= T_CP, "R8 cas precharge", cas_hi, T_CP);
        chk({lat_row, lat_col} == cur_addr, "R2 row/col", {lat_row, lat_col}, cur_addr);
        chk({dram_cash_no, dram_casl_no} == ~cur_be, "R3 lane strobes",
            {dram_cash_no, dram_casl_no}, ~cur_be);
        key = int'({lat_row, lat_col});
        if (!dram_we_no) begin
          chk(!prev_we && dram_dq_oe_o && dram_oe_no, "R4 early write",
              {prev_we, dram_dq_oe_o, dram_oe_no}, 3'b011);
          dram_mem[key] = (mem_get(key) & ~lane_mask(cur_be)) | (dram_dq_o & lane_mask(cur_be));
        end else begin
          chk(!dram_oe_no && !dram_dq_oe_o, "R5 read pins", {dram_oe_no, dram_dq_oe_o}, 0);
        end
        if (!cas_seen) acc_opens++;
        cas_seen = 1'b1;
      end
      if (any && prev_any)
        chk(dram_we_no == prev_we, "R8 we stable in pulse", dram_we_no, prev_we);
      if (!any && prev_any)
        chk(cas_lo >= T_CAS, "R9 cas width", cas_lo, T_CAS);
      if (!prev_ras && dram_ras_no) begin
        chk(ras_lo <= RAS_BOUND, "R11 ras active", ras_lo, RAS_BOUND);
        if (!cas_seen) begin
          chk(lat_row == exp_ref, "R10 refresh row", lat_row, exp_ref);
          if (lat_row == '0 && ref_cnt > 0) saw_wrap = 1'b1;
          exp_ref = exp_ref + 1'b1;
          ref_cnt++;
        end
      end
      ras_lo = dram_ras_no ? 0 : ras_lo + 1;
      ras_hi = dram_ras_no ? ras_hi + 1 : 0;
      cas_lo = any ? cas_lo + 1 : 0;
      cas_hi = any ? 0 : cas_hi + 1;
      prev_ras = dram_ras_no;
      prev_any = any;
      prev_we  = dram_we_no;
      key = int'({lat_row, lat_col});
      dram_dq_i = dram_oe_no ? 16'h0 :
                  (mem_get(key) & lane_mask({!dram_cash_no, !dram_casl_no}));
    end
  end

  always @(negedge clk) begin
    if (rst_ni && rsp_valid_o) begin
      if (exp_q.size() == 0) chk(1'b0, "R5 unexpected response", rsp_rdata_o, 0);
      else begin
        automatic logic [15:0] e = exp_q.pop_front();
        chk(rsp_rdata_o == e, "R5 read data", rsp_rdata_o, e);
      end
    end
  end

  task automatic send(input logic [ROW_W-1:0] row, input logic [COL_W-1:0] col,
                      input bit we, input logic [1:0] be, input logic [15:0] d);
    automatic int key = int'({row, col});
    @(negedge clk);
    req_valid_i = 1'b1; req_addr_i = {row, col}; req_we_i = we; req_be_i = be; req_wdata_i = d;
    while (!req_ready_o) @(negedge clk);
    @(posedge clk);
    cur_addr = {row, col};
    cur_be   = be;
    if (we) model[key] = (model_get(key) & ~lane_mask(be)) | (d & lane_mask(be));
    else    exp_q.push_back(model_get(key) & lane_mask(be));
    @(negedge clk);
    req_valid_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    void'($urandom(32'h1f2e3d4c));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk({dram_ras_no, dram_casl_no, dram_cash_no, dram_we_no, dram_oe_no} == 5'h1f,
        "R1 strobes idle", {dram_ras_no, dram_casl_no, dram_cash_no, dram_we_no, dram_oe_no}, 5'h1f);
    chk(!dram_dq_oe_o && !rsp_valid_o, "R1 driver/resp off", {dram_dq_oe_o, rsp_valid_o}, 0);
    chk(req_ready_o, "R1 ready", req_ready_o, 1);

    // R2/R3/R4/R5 directed byte lanes
    send(8'd3, 10'd5, 1'b1, 2'b11, 16'hA55A);
    send(8'd3, 10'd5, 1'b0, 2'b11, 16'h0);
    send(8'd3, 10'd6, 1'b1, 2'b11, 16'h1234);
    send(8'd3, 10'd6, 1'b1, 2'b01, 16'h99CD);
    send(8'd3, 10'd6, 1'b1, 2'b10, 16'hEF77);
    send(8'd3, 10'd6, 1'b0, 2'b11, 16'h0);
    send(8'd3, 10'd6, 1'b0, 2'b10, 16'h0);
    send(8'd3, 10'd6, 1'b0, 2'b01, 16'h0);

    // R6 page hits right after a refresh
    begin
      automatic int r0 = ref_cnt;
      automatic int o0;
      while (ref_cnt == r0) @(negedge clk);
      o0 = acc_opens;
      for (int i = 0; i < 4; i++) send(8'd40, 10'(i), 1'b1, 2'b11, 16'(16'h4000 + i));
      repeat (6) @(negedge clk);
      chk(acc_opens - o0 == 1, "R6 single row open", acc_opens - o0, 1);
      // R7 miss reopens once
      o0 = acc_opens;
      send(8'd41, 10'd9, 1'b0, 2'b11, 16'h0);
      repeat (10) @(negedge clk);
      chk(acc_opens - o0 == 1, "R7 miss reopen", acc_opens - o0, 1);
    end

    // random mix
    for (int i = 0; i < 400; i++) begin
      automatic logic [ROW_W-1:0] rows [4] = '{8'd0, 8'd1, 8'd77, 8'd255};
      automatic logic [ROW_W-1:0] r = rows[$urandom % 4];
      send(r, 10'($urandom % 8), 1'($urandom % 2), 2'(1 + $urandom % 3), 16'($urandom));
    end
    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R5 all reads answered", exp_q.size(), 0);

    // R10 counter wraps while idle
    while (ref_cnt < (1 << ROW_W) + 2) @(negedge clk);
    chk(saw_wrap, "R10 refresh row wrap", saw_wrap, 1);
    chk(dram_ras_no || !req_ready_o, "R11 idle row", dram_ras_no, 1);
    finish_run();
  end

endmodule